// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate with Doubled Writeback

This block holds two independent multiply-accumulate lanes behind one command port. In each accepted cycle both lanes act at once. Each lane takes two 32-bit source words and picks the upper or lower 16-bit half of each one as a multiplier operand. It then loads its 40-bit accumulator with the product, adds the product to the accumulator, or leaves the accumulator unchanged. The accumulator keeps the plain integer product. The 32-bit value handed back is that accumulator multiplied by two, saturated to the signed 32-bit range.

Lane 1 has one extra option. In mixed mode its first operand is treated as unsigned while the second stays signed. Lane 0 always multiplies two signed operands. A clear input zeroes both accumulators. Each lane also exposes the raw low 32 bits of its accumulator, which lets a caller read the unscaled value next to the doubled result.

Top module: `dmac_pair`

## Requirements
- R1: While `rst_n` is low, at a rising clock edge, both accumulators, both results and `res_valid` become zero.
- R2: For each operand of each lane, a half-select bit of 1 picks bits [31:16] of its source word and 0 picks bits [15:0], independently of every other operand.
- R3: Operation code 2'b01 (load) sets the lane accumulator to the product, sign-extended to 40 bits. For example, 0x6569 times 0x5ABD gives a low word of 0x23F1C885.
- R4: Operation code 2'b10 (accumulate) adds the sign-extended product to the accumulator. The sum wraps modulo 2^40.
- R5: Operation codes 2'b00 and 2'b11 (hold) leave the accumulator unchanged. The result still shows the current accumulator doubled and saturated.
- R6: A lane's result is its accumulator times two. For example, 0x23F1C885 gives 0x47E3910A. The result is registered and appears after the same edge that updates the accumulator.
- R7: Saturation is decided from the full 40-bit accumulator doubled to 41 bits. If the doubled value is above the signed 32-bit range the result is 0x7FFFFFFF. If it is below that range the result is 0x80000000.
- R8: When `l1_mixed` is 1, lane 1 treats operand A as unsigned and operand B as signed. Lane 0 always treats both operands as signed.
- R9: `acc_clear` high at an edge zeroes both accumulators and both results and drives `res_valid` low. It overrides `cmd_valid`.
- R10: `res_valid` is high after an edge exactly when `cmd_valid` was high and `acc_clear` low. With `cmd_valid` low, accumulators and results hold.
- R11: `l0_acc_lo` and `l1_acc_lo` are bits [31:0] of the lane accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| acc_clear | input | 1 | Zero both accumulators |
| l0_src_a | input | 32 | Lane 0 operand A source word |
| l0_src_b | input | 32 | Lane 0 operand B source word |
| l0_hi_a | input | 1 | Lane 0 operand A upper-half select |
| l0_hi_b | input | 1 | Lane 0 operand B upper-half select |
| l0_op | input | 2 | Lane 0 operation (00/11 hold, 01 load, 10 accumulate) |
| l1_src_a | input | 32 | Lane 1 operand A source word |
| l1_src_b | input | 32 | Lane 1 operand B source word |
| l1_hi_a | input | 1 | Lane 1 operand A upper-half select |
| l1_hi_b | input | 1 | Lane 1 operand B upper-half select |
| l1_op | input | 2 | Lane 1 operation (same encoding) |
| l1_mixed | input | 1 | Lane 1 operand A unsigned |
| res_valid | output | 1 | Results reflect a command from the previous edge |
| l0_result | output | 32 | Lane 0 doubled, saturated accumulator |
| l1_result | output | 32 | Lane 1 doubled, saturated accumulator |
| l0_acc_lo | output | 32 | Lane 0 accumulator bits [31:0] |
| l1_acc_lo | output | 32 | Lane 1 accumulator bits [31:0] |

## Verification
A table of mixed-sign operand pairs runs with every combination of half selects. Each entry is compared with a bench model, which separates a wrong half pick from a wrong sign extension. A run of repeated accumulates of 2^30 first pushes one accumulator to exactly 2^32, where the low word is zero but the doubled result must saturate. It then continues until the accumulator wraps past 2^39, which separates a 41-bit saturation decision from one made on the low word, and a wrapping accumulator from a clamping one. The same all-ones operand A is run through both lanes with lane 1 in mixed mode, so the lanes must produce different products. Hold, idle and clear cycles use changed operands, which shows that stale inputs leave no trace.

// File: rtl/dmac_pkg.sv
// Package: shared operation encoding for the dual-lane multiply-accumulate.
// Assumes the command decoder upstream drives these 2-bit codes.
package dmac_pkg;
    typedef enum logic [1:0] {
        MAC_HOLD = 2'b00,
        MAC_LOAD = 2'b01,
        MAC_ADD  = 2'b10,
        MAC_RSVD = 2'b11
    } mac_op_e;
endpackage

// File: rtl/dmac_halfsel.sv
// Module: picks the upper or lower half of a source word as a multiplier operand.
// Assumes SRC_W is twice OPD_W.
module dmac_halfsel #(
    parameter int SRC_W = 32,
    parameter int OPD_W = 16
) (
    input  logic [SRC_W-1:0] src,
    input  logic             hi,
    output logic [OPD_W-1:0] opd
);
    // Half multiplexer.
    always_comb begin
        opd = hi ? src[SRC_W-1:OPD_W] : src[OPD_W-1:0];
    end
endmodule

// File: rtl/dmac_mult.sv
// Module: 16x16 multiplier; operand A may be unsigned when the lane allows it.
// Assumes the product of an unsigned and a signed operand fits in 2*OPD_W signed bits.
module dmac_mult #(
    parameter int OPD_W    = 16,
    parameter bit MIXED_EN = 1'b0
) (
    input  logic [OPD_W-1:0]   opd_a,
    input  logic [OPD_W-1:0]   opd_b,
    input  logic               mixed,
    output logic [2*OPD_W-1:0] prod
);
    localparam int PROD_W = 2 * OPD_W;
    localparam int PAD_W  = PROD_W - OPD_W;

    logic              a_uns;
    logic [PROD_W-1:0] ext_a;
    logic [PROD_W-1:0] ext_b;

    // Mixed mode only takes effect on a lane built with MIXED_EN.
    assign a_uns = MIXED_EN && mixed;

    // Widen operands to product width, then multiply in that width.
    always_comb begin
        ext_a = a_uns ? {{PAD_W{1'b0}}, opd_a} : {{PAD_W{opd_a[OPD_W-1]}}, opd_a};
        ext_b = {{PAD_W{opd_b[OPD_W-1]}}, opd_b};
        prod  = ext_a * ext_b;
    end
endmodule

// File: rtl/dmac_sat.sv
// Module: doubles an accumulator and saturates it to a signed RES_W-bit word.
// Assumes ACC_W >= RES_W; the decision uses every accumulator bit.
module dmac_sat #(
    parameter int ACC_W = 40,
    parameter int RES_W = 32
) (
    input  logic [ACC_W-1:0] acc,
    output logic [RES_W-1:0] res
);
    localparam int DBL_W = ACC_W + 1;
    localparam logic [RES_W-1:0] POS_MAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NEG_MIN = {1'b1, {(RES_W-1){1'b0}}};

    logic [DBL_W-1:0]     dbl;
    logic [DBL_W-RES_W:0] top;
    logic                 fits;

    // Doubled value fits when all bits above the result sign agree.
    always_comb begin
        dbl  = {acc, 1'b0};
        top  = dbl[DBL_W-1:RES_W-1];
        fits = (&top) | ~(|top);
        if (fits) res = dbl[RES_W-1:0];
        else      res = dbl[DBL_W-1] ? NEG_MIN : POS_MAX;
    end
endmodule

// File: rtl/dmac_lane.sv
// Module: one multiply-accumulate lane with a 40-bit accumulator and a registered
// doubled result. Assumes one command per cycle; clear overrides a command.
module dmac_lane
    import dmac_pkg::*;
#(
    parameter int SRC_W    = 32,
    parameter int OPD_W    = 16,
    parameter int ACC_W    = 40,
    parameter int RES_W    = 32,
    parameter bit MIXED_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             clear,
    input  logic [SRC_W-1:0] src_a,
    input  logic [SRC_W-1:0] src_b,
    input  logic             hi_a,
    input  logic             hi_b,
    input  logic [1:0]       op,
    input  logic             mixed,
    output logic [RES_W-1:0] result,
    output logic [RES_W-1:0] acc_lo
);
    localparam int PROD_W = 2 * OPD_W;

    logic [OPD_W-1:0]  opd_a;
    logic [OPD_W-1:0]  opd_b;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  prod_ext;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_next;
    logic [RES_W-1:0]  sat_next;
    logic [RES_W-1:0]  res_q;

    dmac_halfsel #(.SRC_W(SRC_W), .OPD_W(OPD_W)) u_sel_a (
        .src (src_a), .hi (hi_a), .opd (opd_a)
    );
    dmac_halfsel #(.SRC_W(SRC_W), .OPD_W(OPD_W)) u_sel_b (
        .src (src_b), .hi (hi_b), .opd (opd_b)
    );
    dmac_mult #(.OPD_W(OPD_W), .MIXED_EN(MIXED_EN)) u_mult (
        .opd_a (opd_a), .opd_b (opd_b), .mixed (mixed), .prod (prod)
    );

    // Next accumulator value for the requested operation; wraps at ACC_W bits.
    always_comb begin
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        case (mac_op_e'(op))
            MAC_LOAD: acc_next = prod_ext;
            MAC_ADD:  acc_next = acc_q + prod_ext;
            default:  acc_next = acc_q;
        endcase
    end

    dmac_sat #(.ACC_W(ACC_W), .RES_W(RES_W)) u_sat (
        .acc (acc_next), .res (sat_next)
    );

    // Accumulator and result registers, updated together on an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
            res_q <= '0;
        end else if (cmd_valid) begin
            acc_q <= acc_next;
            res_q <= sat_next;
        end
    end

    assign result = res_q;
    assign acc_lo = acc_q[RES_W-1:0];
endmodule

// File: rtl/dmac_pair.sv
// Module: top of the dual-lane multiply-accumulate. Lane 1 carries the mixed
// signed/unsigned option, lane 0 does not. Assumes synchronous active-low reset.
module dmac_pair #(
    parameter int SRC_W = 32,
    parameter int OPD_W = 16,
    parameter int ACC_W = 40,
    parameter int RES_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             acc_clear,
    input  logic [SRC_W-1:0] l0_src_a,
    input  logic [SRC_W-1:0] l0_src_b,
    input  logic             l0_hi_a,
    input  logic             l0_hi_b,
    input  logic [1:0]       l0_op,
    input  logic [SRC_W-1:0] l1_src_a,
    input  logic [SRC_W-1:0] l1_src_b,
    input  logic             l1_hi_a,
    input  logic             l1_hi_b,
    input  logic [1:0]       l1_op,
    input  logic             l1_mixed,
    output logic             res_valid,
    output logic [RES_W-1:0] l0_result,
    output logic [RES_W-1:0] l1_result,
    output logic [RES_W-1:0] l0_acc_lo,
    output logic [RES_W-1:0] l1_acc_lo
);
    localparam int NLANES = 2;

    logic [NLANES-1:0][SRC_W-1:0] v_src_a;
    logic [NLANES-1:0][SRC_W-1:0] v_src_b;
    logic [NLANES-1:0]            v_hi_a;
    logic [NLANES-1:0]            v_hi_b;
    logic [NLANES-1:0][1:0]       v_op;
    logic [NLANES-1:0]            v_mixed;
    logic [NLANES-1:0][RES_W-1:0] v_result;
    logic [NLANES-1:0][RES_W-1:0] v_acc_lo;
    logic                         valid_q;

    // Gather per-lane ports into vectors; lane 0 has no mixed option.
    always_comb begin
        v_src_a = {l1_src_a, l0_src_a};
        v_src_b = {l1_src_b, l0_src_b};
        v_hi_a  = {l1_hi_a, l0_hi_a};
        v_hi_b  = {l1_hi_b, l0_hi_b};
        v_op    = {l1_op, l0_op};
        v_mixed = {l1_mixed, 1'b0};
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        dmac_lane #(
            .SRC_W    (SRC_W),
            .OPD_W    (OPD_W),
            .ACC_W    (ACC_W),
            .RES_W    (RES_W),
            .MIXED_EN (g == 1)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_valid (cmd_valid),
            .clear     (acc_clear),
            .src_a     (v_src_a[g]),
            .src_b     (v_src_b[g]),
            .hi_a      (v_hi_a[g]),
            .hi_b      (v_hi_b[g]),
            .op        (v_op[g]),
            .mixed     (v_mixed[g]),
            .result    (v_result[g]),
            .acc_lo    (v_acc_lo[g])
        );
    end

    // Result strobe: one cycle after an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_clear) valid_q <= 1'b0;
        else                     valid_q <= cmd_valid;
    end

    assign res_valid = valid_q;
    assign l0_result = v_result[0];
    assign l1_result = v_result[1];
    assign l0_acc_lo = v_acc_lo[0];
    assign l1_acc_lo = v_acc_lo[1];
endmodule

// File: rtl/dmac_pair_chk.sv
// Module: temporal checks on the dual-lane multiply-accumulate ports, bound to the top.
// Assumes the default 32-bit result width.
module dmac_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        acc_clear,
    input logic [1:0]  l0_op,
    input logic [1:0]  l1_op,
    input logic        res_valid,
    input logic [31:0] l0_result,
    input logic [31:0] l1_result,
    input logic [31:0] l0_acc_lo,
    input logic [31:0] l1_acc_lo
);
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !acc_clear) |=> res_valid);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !acc_clear) |=> ($stable(l0_result) && $stable(l1_result) && !res_valid));

    assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clear |=> (l0_acc_lo == 32'h0 && l1_acc_lo == 32'h0 && !res_valid));

    assert_hold_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !acc_clear && (l0_op == 2'b00 || l0_op == 2'b11)) |=> $stable(l0_acc_lo));

    assert_hold_lane1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !acc_clear && (l1_op == 2'b00 || l1_op == 2'b11)) |=> $stable(l1_acc_lo));

    assert_even_or_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((l0_result[0] == 1'b0 || l0_result == 32'h7FFFFFFF) &&
                       (l1_result[0] == 1'b0 || l1_result == 32'h7FFFFFFF)));
endmodule

bind dmac_pair dmac_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .acc_clear (acc_clear),
    .l0_op     (l0_op),
    .l1_op     (l1_op),
    .res_valid (res_valid),
    .l0_result (l0_result),
    .l1_result (l1_result),
    .l0_acc_lo (l0_acc_lo),
    .l1_acc_lo (l1_acc_lo)
);

// File: tb/dmac_pair_tb.sv
// Bench: vector table walked against a bench model, then directed corner cases.
module dmac_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        acc_clear = 1'b0;
    logic [31:0] l0_src_a = '0, l0_src_b = '0, l1_src_a = '0, l1_src_b = '0;
    logic        l0_hi_a = 1'b0, l0_hi_b = 1'b0, l1_hi_a = 1'b0, l1_hi_b = 1'b0;
    logic [1:0]  l0_op = 2'b00, l1_op = 2'b00;
    logic        l1_mixed = 1'b0;
    logic        res_valid;
    logic [31:0] l0_result, l1_result, l0_acc_lo, l1_acc_lo;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    longint m_acc [2];

    always #10 clk = ~clk;

    dmac_pair u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .acc_clear(acc_clear),
        .l0_src_a(l0_src_a), .l0_src_b(l0_src_b), .l0_hi_a(l0_hi_a), .l0_hi_b(l0_hi_b),
        .l0_op(l0_op), .l1_src_a(l1_src_a), .l1_src_b(l1_src_b), .l1_hi_a(l1_hi_a),
        .l1_hi_b(l1_hi_b), .l1_op(l1_op), .l1_mixed(l1_mixed), .res_valid(res_valid),
        .l0_result(l0_result), .l1_result(l1_result), .l0_acc_lo(l0_acc_lo),
        .l1_acc_lo(l1_acc_lo)
    );

    typedef struct packed {
        logic [1:0]  op0;
        logic        ha0;
        logic        hb0;
        logic [31:0] a0;
        logic [31:0] b0;
        logic [1:0]  op1;
        logic        mx1;
        logic        ha1;
        logic        hb1;
        logic [31:0] a1;
        logic [31:0] b1;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'b01, 1'b0, 1'b0, 32'hefb86569, 32'h63545abd, 2'b10, 1'b0, 1'b0, 1'b0, 32'hefb86569, 32'h63545abd},
        '{2'b01, 1'b1, 1'b0, 32'h00860007, 32'h86bcfec7, 2'b01, 1'b0, 1'b0, 1'b0, 32'h00860007, 32'h86bcfec7},
        '{2'b10, 1'b1, 1'b1, 32'h678e0086, 32'ha8645679, 2'b01, 1'b0, 1'b0, 1'b1, 32'h678e0086, 32'ha8645679},
        '{2'b10, 1'b0, 1'b1, 32'h1235860b, 32'h000c086d, 2'b10, 1'b0, 1'b1, 1'b1, 32'h1235860b, 32'h000c086d},
        '{2'b01, 1'b1, 1'b1, 32'h91bcfec7, 32'hd0910007, 2'b10, 1'b1, 1'b0, 1'b0, 32'hfec791bc, 32'h0007d091},
        '{2'b00, 1'b0, 1'b0, 32'hdeadbeef, 32'h12345678, 2'b10, 1'b1, 1'b1, 1'b0, 32'h9ec7abd6, 32'h459d7136},
        '{2'b10, 1'b0, 1'b0, 32'h80008000, 32'h80008000, 2'b11, 1'b1, 1'b0, 1'b1, 32'hffffffff, 32'hffffffff},
        '{2'b10, 1'b1, 1'b0, 32'h7fff0001, 32'h8000ffff, 2'b01, 1'b1, 1'b1, 1'b0, 32'h8000ffff, 32'h7fff8000}
    };

    // Model: pick a half and widen it as signed or unsigned.
    function automatic longint pick(input logic [31:0] src, input logic hi, input logic uns);
        logic [15:0] h;
        h = hi ? src[31:16] : src[15:0];
        if (uns) return longint'({48'h0, h});
        return longint'($signed(h));
    endfunction

    // Model: keep 40 bits and sign-extend from bit 39.
    function automatic longint wrap40(input longint v);
        logic [39:0] t;
        t = v[39:0];
        return longint'($signed(t));
    endfunction

    // Model: double and clamp to the signed 32-bit range.
    function automatic logic [31:0] dsat(input longint acc);
        longint d;
        d = acc * 2;
        if (d > 64'sh7FFFFFFF) return 32'h7FFFFFFF;
        if (d < -64'sh80000000) return 32'h80000000;
        return d[31:0];
    endfunction

    function automatic longint next_acc(input longint acc, input logic [1:0] op, input longint p);
        if (op == 2'b01) return wrap40(p);
        if (op == 2'b10) return wrap40(acc + p);
        return acc;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic chk_model(input string req);
        chk({31'h0, res_valid}, 32'h1, {req, " R10 res_valid"});
        chk(l0_acc_lo, m_acc[0][31:0], {req, " R11 lane0 acc_lo"});
        chk(l1_acc_lo, m_acc[1][31:0], {req, " R11 lane1 acc_lo"});
        chk(l0_result, dsat(m_acc[0]), {req, " R6 lane0 result"});
        chk(l1_result, dsat(m_acc[1]), {req, " R6 lane1 result"});
    endtask

    // Apply one command at the current negedge, step one edge, update the model.
    task automatic cmd(input vec_t v);
        l0_op = v.op0; l0_hi_a = v.ha0; l0_hi_b = v.hb0; l0_src_a = v.a0; l0_src_b = v.b0;
        l1_op = v.op1; l1_mixed = v.mx1; l1_hi_a = v.ha1; l1_hi_b = v.hb1;
        l1_src_a = v.a1; l1_src_b = v.b1;
        cmd_valid = 1'b1;
        m_acc[0] = next_acc(m_acc[0], v.op0, pick(v.a0, v.ha0, 1'b0) * pick(v.b0, v.hb0, 1'b0));
        m_acc[1] = next_acc(m_acc[1], v.op1, pick(v.a1, v.ha1, v.mx1) * pick(v.b1, v.hb1, 1'b0));
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        m_acc[0] = 0;
        m_acc[1] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({31'h0, res_valid}, 32'h0, "R1 res_valid in reset");
        chk(l0_acc_lo, 32'h0, "R1 lane0 acc_lo");
        chk(l1_acc_lo, 32'h0, "R1 lane1 acc_lo");
        chk(l0_result, 32'h0, "R1 lane0 result");
        chk(l1_result, 32'h0, "R1 lane1 result");
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R6 literal: 0x6569*0x5ABD loaded and accumulated from zero
        cmd(VECS[0]);
        chk(l0_acc_lo, 32'h23F1C885, "R3 load product");
        chk(l0_result, 32'h47E3910A, "R6 doubled");
        chk(l1_acc_lo, 32'h23F1C885, "R4 accumulate from zero");

        // R2/R3/R4/R8: table walk against the model
        for (int i = 1; i < NVEC; i++) begin
            cmd(VECS[i]);
            chk_model("R2 R3 R4 R8 table");
        end

        // R2 literal: low half of A (3) times high half of B (5)
        cmd('{2'b01, 1'b0, 1'b1, 32'h12340003, 32'h0005ffff, 2'b01, 1'b0, 1'b1, 1'b0, 32'h00070009, 32'h0002fff0});
        chk(l0_acc_lo, 32'h0000000F, "R2 lane0 lo*hi");
        chk(l1_acc_lo, 32'hFFFFFF90, "R2 lane1 hi*lo");

        // R8: same operands, lane 1 mixed (A unsigned), lane 0 signed
        cmd('{2'b01, 1'b0, 1'b0, 32'h0000ffff, 32'h00000002, 2'b01, 1'b1, 1'b0, 1'b0, 32'h0000ffff, 32'h00000002});
        chk(l0_acc_lo, 32'hFFFFFFFE, "R8 lane0 signed");
        chk(l0_result, 32'hFFFFFFFC, "R8 lane0 result");
        chk(l1_acc_lo, 32'h0001FFFE, "R8 lane1 mixed");
        chk(l1_result, 32'h0003FFFC, "R8 lane1 result");

        // R5: hold codes 00 and 11 with new operands change nothing
        cmd('{2'b00, 1'b1, 1'b1, 32'h7fff7fff, 32'h7fff7fff, 2'b11, 1'b1, 1'b1, 1'b1, 32'h7fff7fff, 32'h7fff7fff});
        chk(l0_acc_lo, 32'hFFFFFFFE, "R5 lane0 hold acc");
        chk(l0_result, 32'hFFFFFFFC, "R5 lane0 hold result");
        chk(l1_acc_lo, 32'h0001FFFE, "R5 lane1 hold acc");
        chk(l1_result, 32'h0003FFFC, "R5 lane1 hold result");

        // R10: idle cycle with changed operands
        l0_op = 2'b01; l1_op = 2'b01; l0_src_a = 32'h12345678;
        @(posedge clk); @(negedge clk);
        chk({31'h0, res_valid}, 32'h0, "R10 idle valid low");
        chk(l0_acc_lo, 32'hFFFFFFFE, "R10 idle lane0 acc");
        chk(l1_result, 32'h0003FFFC, "R10 idle lane1 result");

        // R7 negative: -0x3FFF8000 then -0x7FFF0000
        cmd('{2'b01, 1'b1, 1'b0, 32'h80000000, 32'h00007fff, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0});
        chk(l0_acc_lo, 32'hC0008000, "R7 neg load acc");
        chk(l0_result, 32'h80010000, "R7 neg fits");
        cmd('{2'b10, 1'b1, 1'b0, 32'h80000000, 32'h00007fff, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0});
        chk(l0_acc_lo, 32'h80010000, "R7 neg acc");
        chk(l0_result, 32'h80000000, "R7 neg saturate");

        // R7 positive and full-width: 2^30 loaded, then up to 2^32
        cmd('{2'b01, 1'b1, 1'b1, 32'h80000000, 32'h80000000, 2'b01, 1'b0, 1'b1, 1'b1, 32'h80000000, 32'h80000000});
        chk(l0_acc_lo, 32'h40000000, "R7 pos acc");
        chk(l0_result, 32'h7FFFFFFF, "R7 pos saturate");
        for (int k = 0; k < 3; k++)
            cmd('{2'b10, 1'b1, 1'b1, 32'h80000000, 32'h80000000, 2'b10, 1'b0, 1'b1, 1'b1, 32'h80000000, 32'h80000000});
        chk(l0_acc_lo, 32'h00000000, "R7 2^32 low word zero");
        chk(l0_result, 32'h7FFFFFFF, "R7 2^32 saturates from 40 bits");

        // R4 wrap: lane 1 keeps adding 2^30 until it crosses 2^39
        for (int k = 0; k < 507; k++)
            cmd('{2'b00, 1'b0, 1'b0, 32'h0, 32'h0, 2'b10, 1'b0, 1'b1, 1'b1, 32'h80000000, 32'h80000000});
        chk(l1_result, 32'h7FFFFFFF, "R4 just below wrap");
        chk_model("R4 below wrap");
        cmd('{2'b00, 1'b0, 1'b0, 32'h0, 32'h0, 2'b10, 1'b0, 1'b1, 1'b1, 32'h80000000, 32'h80000000});
        chk(l1_acc_lo, 32'h00000000, "R4 wrapped acc");
        chk(l1_result, 32'h80000000, "R4 wrapped negative saturate");

        // R9: clear with a command present
        l0_op = 2'b01; l1_op = 2'b01; cmd_valid = 1'b1; acc_clear = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0; acc_clear = 1'b0;
        m_acc[0] = 0; m_acc[1] = 0;
        chk({31'h0, res_valid}, 32'h0, "R9 valid low");
        chk(l0_acc_lo, 32'h0, "R9 lane0 acc");
        chk(l1_acc_lo, 32'h0, "R9 lane1 acc");
        chk(l0_result, 32'h0, "R9 lane0 result");
        chk(l1_result, 32'h0, "R9 lane1 result");

        // R1: reset mid-run
        cmd(VECS[3]);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(l0_acc_lo, 32'h0, "R1 lane0 after reset");
        chk(l1_result, 32'h0, "R1 lane1 after reset");
        chk({31'h0, res_valid}, 32'h0, "R1 valid after reset");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule